// File: doc/BRIEF.md
# Dual-clock FIFO with encoded fill flags

This block is a first-in first-out buffer whose write side and read side each run on their own clock. A word is stored on a rising write-clock edge while the active-low write enable is low. A word is fetched onto the data output on a rising read-clock edge while the active-low read enable is low. A write into a full buffer is discarded. A read from an empty buffer is discarded, and the output keeps the last word that was read.

Fill status leaves the block on two pins that together carry a two-bit code. The part of the code that reports emptiness and low fill is registered by the read clock. The part that reports near-full is registered by the write clock. Each part is refreshed on every edge of its own clock, whether or not that side's enable is asserted. As a result, the code can lag the true fill level until the owning clock has ticked. The pointers cross between the domains in gray code through two-flop synchronizers. A write or read that lands inside the synchronizer window may or may not be counted at the next refresh.

Top module: `dcf_fifo`

## Requirements
- R1: Words leave the read port in the order they were written. Each read-clock edge with `rd_en_ni` low and the buffer not empty replaces `rd_data_o` with the next stored word.
- R2: When `DEPTH` words are stored, a write attempt is discarded. The stored contents and later reads are unchanged, and the flags keep reporting near-full.
- R3: A read attempt on an empty buffer is discarded. `rd_data_o` keeps the last word that was read. A later write followed by a read still returns that written word.
- R4: The code {`flag_a_o`,`flag_b_o`} is as follows:
  - 00 when the buffer holds 0 words.
  - 10 for 1 to `LOW_MARK` words.
  - 11 for `LOW_MARK`+1 to `DEPTH`-`LOW_MARK`-1 words.
  - 01 for `DEPTH`-`LOW_MARK` to `DEPTH` words.
  
  The code holds once both clocks have made a few edges with no access.
- R5: The empty and low-fill parts of the code change only on read-clock edges. With the read clock stopped, writes leave the code at its old value (00 from empty). The code catches up after a few read-clock edges, even with `rd_en_ni` held high.
- R6: The near-full indication is registered on write-clock edges. It is set from the write edge that brings the count to `DEPTH`-`LOW_MARK`, and it stays set while the buffer is full.
- R7: While `rst_ni` is low, both pointers clear. After reset, `rd_data_o` is all zeros and the code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write clock |
| rd_clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| wr_en_ni | input | 1 | Active-low write enable |
| wr_data_i | input | DW | Write data |
| rd_en_ni | input | 1 | Active-low read enable |
| rd_data_o | output | DW | Registered read data |
| flag_a_o | output | 1 | Code bit 1: not empty and not near-full |
| flag_b_o | output | 1 | Code bit 0: read-side count above LOW_MARK |

## Verification
The hardest situation to reach is a stale code. This means the fill level has crossed a boundary but the owning clock has not ticked since. The bench gates the read clock off and writes past the low mark. It checks that the code still reads empty. It then restarts the read clock with the enable held inactive and confirms the code jumps to the intermediate value. The fill and drain sweeps then walk every level from 0 to `DEPTH`. This crosses every code boundary in both directions, including overflow and underflow attempts at the ends.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_LOW   = 2'b10,
    FILL_MID   = 2'b11,
    FILL_HIGH  = 2'b01
  } fill_code_t;

  // bit1 from both domains' registers, bit0 from read domain only
  function automatic fill_code_t fill_code(logic rd_empty_q, logic rd_above_q, logic wr_high_q);
    return fill_code_t'({~rd_empty_q & ~wr_high_q, rd_above_q});
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int DEPTH    = 512,
  parameter int LOW_MARK = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_ni,
  input  logic [PW-1:0] rgray_sync_i,
  output logic [PW-1:0] wgray_o,
  output logic [PW-1:0] wbin_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output logic          full_o,
  output logic          high_o
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HIGH_CNT = PW'(DEPTH - LOW_MARK);

  logic [PW-1:0] wbin_q, wgray_q, rbin, cnt, cnt_nxt, wbin_nxt;
  logic          high_q, fire;

  always_comb begin
    rbin[PW-1] = rgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_sync_i[i];
  end

  assign cnt      = wbin_q - rbin;
  assign full_o   = (cnt == FULL_CNT);
  assign fire     = !en_ni && !full_o;
  assign cnt_nxt  = cnt + PW'(fire);
  assign wbin_nxt = wbin_q + PW'(fire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      high_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      high_q  <= (cnt_nxt >= HIGH_CNT);
    end
  end

  assign wgray_o = wgray_q;
  assign wbin_o  = wbin_q;
  assign waddr_o = wbin_q[AW-1:0];
  assign we_o    = fire;
  assign high_o  = high_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int DEPTH    = 512,
  parameter int LOW_MARK = 16,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_ni,
  input  logic [PW-1:0] wgray_sync_i,
  output logic [PW-1:0] rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          re_o,
  output logic          empty_o,
  output logic          empty_q_o,
  output logic          above_q_o
);
  localparam logic [PW-1:0] LOW_CNT = PW'(LOW_MARK);

  logic [PW-1:0] rbin_q, rgray_q, wbin, cnt, cnt_nxt, rbin_nxt;
  logic          empty_q, above_q, fire;

  always_comb begin
    wbin[PW-1] = wgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync_i[i];
  end

  assign cnt      = wbin - rbin_q;
  assign empty_o  = (cnt == '0);
  assign fire     = !en_ni && !empty_o;
  assign cnt_nxt  = cnt - PW'(fire);
  assign rbin_nxt = rbin_q + PW'(fire);

  // refresh on every edge, enable or not
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
      above_q <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      empty_q <= (cnt_nxt == '0);
      above_q <= (cnt_nxt > LOW_CNT);
    end
  end

  assign rgray_o   = rgray_q;
  assign raddr_o   = rbin_q[AW-1:0];
  assign re_o      = fire;
  assign empty_q_o = empty_q;
  assign above_q_o = above_q;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW    = 9,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge wr_clk_i)
    if (we_i) mem_q[waddr_i] <= wdata_i;

  always_ff @(posedge rd_clk_i or negedge rst_ni)
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int DW       = 9,
  parameter int DEPTH    = 512,
  parameter int LOW_MARK = 16,
  parameter int SYNC     = 2
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_ni,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_ni,
  output logic [DW-1:0] rd_data_o,
  output logic          flag_a_o,
  output logic          flag_b_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws, wbin;
  logic [AW-1:0] waddr, raddr;
  logic          we, re, wr_full, wr_high, rd_empty, rd_empty_q, rd_above_q;
  fill_code_t    code;

  dcf_wr_ctrl #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) wr_i (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .en_ni(wr_en_ni),
    .rgray_sync_i(rgray_ws), .wgray_o(wgray), .wbin_o(wbin),
    .waddr_o(waddr), .we_o(we), .full_o(wr_full), .high_o(wr_high)
  );

  dcf_rd_ctrl #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) rd_i (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .en_ni(rd_en_ni),
    .wgray_sync_i(wgray_rs), .rgray_o(rgray), .raddr_o(raddr),
    .re_o(re), .empty_o(rd_empty), .empty_q_o(rd_empty_q), .above_q_o(rd_above_q)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC)) w2r_i (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_rs)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC)) r2w_i (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_ws)
  );

  dcf_mem #(.DW(DW), .DEPTH(DEPTH)) mem_i (
    .wr_clk_i(wr_clk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wr_data_i),
    .rd_clk_i(rd_clk_i), .rst_ni(rst_ni), .re_i(re), .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  assign code     = fill_code(rd_empty_q, rd_above_q, wr_high);
  assign flag_a_o = code[1];
  assign flag_b_o = code[0];
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int DW = 9,
  parameter int PW = 10
) (
  input logic          wr_clk_i,
  input logic          rd_clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] rd_data_o,
  input logic          flag_a_o,
  input logic          flag_b_o,
  input logic          wr_full,
  input logic          rd_empty,
  input logic [PW-1:0] wbin
);
  a_r2_no_overflow: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_full |=> $stable(wbin));

  a_r1_ptr_step: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wbin - $past(wbin)) <= PW'(1));

  a_r3_hold_on_empty: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_empty |=> $stable(rd_data_o));

  a_r5_empty_clears_low: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    rd_empty |=> !flag_a_o && !flag_b_o);

  a_r6_high_when_full: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_full |=> !flag_a_o);
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .PW(PW)) chk_i (
  .wr_clk_i(wr_clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni),
  .rd_data_o(rd_data_o), .flag_a_o(flag_a_o), .flag_b_o(flag_b_o),
  .wr_full(wr_full), .rd_empty(rd_empty), .wbin(wbin)
);

// File: tb/dcf_fifo_tb_top.sv
module dcf_fifo_tb_top;
  localparam int DW    = 9;
  localparam int DEPTH = 64;
  localparam int MARK  = 16;

  logic wr_clk = 1'b0, rd_raw = 1'b0, rd_run = 1'b1, rst_n = 1'b0;
  logic wr_en_n = 1'b1, rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic fa, fb, rd_clk;

  int checks = 0, errors = 0;
  int fill = 0, wr_idx = 0, rd_idx = 0;
  logic [DW-1:0] last_rd;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_raw = ~rd_raw;
  assign rd_clk = rd_raw & rd_run;

  dcf_fifo #(.DW(DW), .DEPTH(DEPTH), .LOW_MARK(MARK)) dut_i (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_n),
    .wr_en_ni(wr_en_n), .wr_data_i(wr_data), .rd_en_ni(rd_en_n),
    .rd_data_o(rd_data), .flag_a_o(fa), .flag_b_o(fb)
  );

  function automatic logic [DW-1:0] word_of(int n);
    return DW'((n * 37 + 5) % (1 << DW));
  endfunction

  function automatic logic [1:0] code_of(int k);
    if (k == 0)                return 2'b00;
    else if (k <= MARK)        return 2'b10;
    else if (k < DEPTH - MARK) return 2'b11;
    else                       return 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (fill %0d)", req, act, exp, fill);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge rd_clk);
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk);
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge wr_clk);
    wr_en_n = 1'b0; wr_data = v;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(negedge rd_clk);
    rd_en_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge wr_clk);
    @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
    // R7 reset state
    chk(rd_data == '0, "R7 data", int'(rd_data), 0);
    chk({fa, fb} == 2'b00, "R7 flags", int'({fa, fb}), 0);

    // R5 stale: read clock gated off while filling past the low mark
    @(negedge rd_raw); #1 rd_run = 1'b0;
    for (int i = 0; i < 20; i++) begin
      push(word_of(wr_idx)); wr_idx++; fill++;
    end
    rd_en_n = 1'b0;
    repeat (10) @(posedge wr_clk);
    @(negedge wr_clk);
    chk({fa, fb} == 2'b00, "R5 stale", int'({fa, fb}), 0);
    rd_en_n = 1'b1;
    @(negedge rd_raw); #1 rd_run = 1'b1;
    settle();
    chk({fa, fb} == code_of(fill), "R5 refreshed", int'({fa, fb}), int'(code_of(fill)));
    chk(rd_data == '0, "R5 no read while gated", int'(rd_data), 0);

    // R4/R6 fill sweep
    while (fill < DEPTH) begin
      push(word_of(wr_idx)); wr_idx++; fill++;
      settle();
      chk({fa, fb} == code_of(fill), fill >= DEPTH - MARK ? "R6 fill" : "R4 fill",
          int'({fa, fb}), int'(code_of(fill)));
    end

    // R2 overflow attempts
    for (int i = 0; i < 3; i++) push(9'h1AA);
    settle();
    chk({fa, fb} == 2'b01, "R2 flags at full", int'({fa, fb}), 1);

    // R1/R4 drain sweep, data order
    while (fill > 0) begin
      pop();
      chk(rd_data == word_of(rd_idx), "R1 order", int'(rd_data), int'(word_of(rd_idx)));
      last_rd = word_of(rd_idx);
      rd_idx++; fill--;
      settle();
      chk({fa, fb} == code_of(fill), "R4 drain", int'({fa, fb}), int'(code_of(fill)));
    end
    chk(rd_idx == DEPTH, "R2 no extra word", rd_idx, DEPTH);

    // R3 underflow
    for (int i = 0; i < 3; i++) begin
      pop();
      chk(rd_data == last_rd, "R3 hold", int'(rd_data), int'(last_rd));
    end
    settle();
    chk({fa, fb} == 2'b00, "R3 flags empty", int'({fa, fb}), 0);
    push(9'h0C3); fill++;
    settle();
    chk({fa, fb} == 2'b10, "R4 one word", int'({fa, fb}), 2);
    pop(); fill--;
    chk(rd_data == 9'h0C3, "R3 after underflow", int'(rd_data), 'h0C3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule